// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing protocol engine of a 256-byte two-wire serial memory. It samples the SCL and SDA wires on a fast system clock. Both samples pass through a two-flop synchronizer and a short majority-free glitch filter. The engine finds Start and Stop conditions and shifts bytes in MSB first. It only ever pulls SDA low through an open-drain enable.

A transaction begins with a control byte. That byte carries a fixed device code, three chip-select bits that must match the strap inputs, and a read/write flag. In a write, the next byte sets an 8-bit address pointer. Each byte after that is handed to a companion page-write block on a one-cycle strobe, and a Stop after at least one data byte requests the commit. Reads return memory bytes from the pointer. They support current-address, random (through a repeated Start) and sequential access. While the companion's programming cycle is busy, the engine acknowledges nothing.

Top module: `ee_bus_slave`

## Requirements
- R1: While reset is held, `sda_oe`, `wr_valid` and `wr_commit` are low, and the engine waits for a Start.
- R2: The first byte after a Start is acknowledged only if bits [7:4] are 4'b1010 and bits [3:1] equal `cs_strap[2:0]` (bit 3 against strap bit 2). The acknowledge holds SDA low through the whole ninth SCL high phase. A mismatching byte gets no acknowledge, and every later byte is ignored until the next Start.
- R3: While `busy` is high, no byte is acknowledged, including the control byte.
- R4: In a write (control bit 0 = 0), the byte after the control byte loads the address pointer. Each following byte is acknowledged and reported by a single-cycle `wr_valid`, with `wr_addr` set to the pointer and `wr_data` set to the byte.
- R5: After each written byte, only the low four pointer bits increment, so a write wraps inside its 16-byte page (0x1F is followed by 0x10).
- R6: A Stop that ends a write with at least one data byte gives exactly one single-cycle `wr_commit` pulse. A write that carries only an address gives none.
- R7: A repeated Start after the address byte, followed by a matching read control byte (bit 0 = 1), returns the byte at the newly loaded address.
- R8: Read data leaves MSB first, and SDA changes only while SCL is low. After each byte the master acknowledges, the pointer advances by one and wraps from 0xFF to 0x00.
- R9: When the master does not acknowledge a read byte, the engine releases SDA and goes idle, and the pointer keeps the address of that last byte. A later current-address read returns that same byte again.
- R10: A low pulse on SDA of one system clock while SCL is high is treated neither as a Start nor as a Stop, and it does not corrupt the bit being received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL wire level |
| sda_in | input | 1 | Raw SDA wire level |
| cs_strap | input | 3 | Chip-select strap levels {A2,A1,A0} |
| busy | input | 1 | Programming cycle in progress (from page-write block) |
| rd_data | input | 8 | Memory byte at `rd_addr` |
| sda_oe | output | 1 | 1 pulls SDA low |
| rd_addr | output | 8 | Current address pointer |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 8 | Address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| wr_commit | output | 1 | One-cycle request to program the page |

## Verification
The engine is driven by a bit-level bus master. It runs a matching and a non-matching control byte (wrong strap, wrong code) to separate selection from device-code decoding. A single-byte write and a three-byte write crossing 0x1F show the plain pointer load apart from the in-page wrap. Random, sequential (crossing 0xFF) and current-address reads separate the pointer load, the increment on acknowledge and the hold on a master nack. A busy window and a one-clock SDA glitch inside a data bit test acknowledge suppression and the input filter.

// File: rtl/ee_bus_slave.sv
module ee_bus_slave #(
  parameter int FILT      = 3,
  parameter int PAGE_BITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] cs_strap,
  input  logic       busy,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic [7:0] rd_addr,
  output logic       wr_valid,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       wr_commit
);

  typedef enum logic [2:0] {ST_IDLE, ST_CTRL, ST_ADDR, ST_WDAT, ST_RDAT} st_t;

  logic [1:0]      scl_s, sda_s;
  logic [FILT-1:0] scl_h, sda_h;
  logic            scl_f, sda_f, scl_q, sda_q;
  st_t             st;
  logic [3:0]      cnt;
  logic [7:0]      shreg, ptr;
  logic            rw, wrote;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_in};
      sda_s <= {sda_s[0], sda_in};
      scl_h <= {scl_h[FILT-2:0], scl_s[1]};
      sda_h <= {sda_h[FILT-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_q <= scl_f;
      sda_q <= sda_f;
    end

  wire start_c  = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c   = scl_f & scl_q & ~sda_q & sda_f;
  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire sel_ok   = (shreg[7:4] == 4'b1010) && (shreg[3:1] == cs_strap);
  wire ack_now  = !busy && (st != ST_CTRL || sel_ok);

  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; shreg <= '0; ptr <= '0; rw <= 1'b0; wrote <= 1'b0;
      sda_oe <= 1'b0; wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_commit <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      if (stop_c) begin
        st <= ST_IDLE; sda_oe <= 1'b0; wr_commit <= wrote; wrote <= 1'b0;
      end else if (start_c) begin
        st <= ST_CTRL; cnt <= '0; sda_oe <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) begin
            cnt <= cnt + 4'd1;
            if (st != ST_RDAT) shreg <= {shreg[6:0], sda_f};
          end else if (cnt == 4'd9 && st == ST_RDAT) begin
            if (!sda_f) begin ptr <= ptr + 8'd1; cnt <= 4'd10; end
            else st <= ST_IDLE;
          end
        end else if (scl_fall) begin
          if (st == ST_RDAT) begin
            if (cnt >= 4'd1 && cnt <= 4'd7) sda_oe <= ~shreg[3'd7 - cnt[2:0]];
            else if (cnt == 4'd8) begin sda_oe <= 1'b0; cnt <= 4'd9; end
            else if (cnt == 4'd10) begin shreg <= rd_data; sda_oe <= ~rd_data[7]; cnt <= '0; end
          end else if (cnt == 4'd8) begin
            if (!ack_now) begin
              st <= ST_IDLE; sda_oe <= 1'b0;
            end else begin
              sda_oe <= 1'b1; cnt <= 4'd9;
              case (st)
                ST_CTRL: rw <= shreg[0];
                ST_ADDR: ptr <= shreg;
                default: begin
                  wr_valid <= 1'b1; wr_addr <= ptr; wr_data <= shreg; wrote <= 1'b1;
                  ptr <= {ptr[7:PAGE_BITS], ptr[PAGE_BITS-1:0] + 1'b1};
                end
              endcase
            end
          end else if (cnt == 4'd9) begin
            sda_oe <= 1'b0; cnt <= '0;
            case (st)
              ST_CTRL: if (rw) begin st <= ST_RDAT; shreg <= rd_data; sda_oe <= ~rd_data[7]; end
                       else st <= ST_ADDR;
              ST_ADDR: st <= ST_WDAT;
              default: ;
            endcase
          end
        end
      end
    end

  p_start_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> !sda_oe);
  p_busy_noack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CTRL && $rose(sda_oe)) |-> $past(!busy));
  p_wr_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(!busy));
  p_commit_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);
  p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!scl_f || start_c || stop_c || $past(start_c || stop_c)));

endmodule

// File: tb/test_ee_bus_slave.sv
module test_ee_bus_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] cs_strap = 3'b101;
  logic busy = 1'b0;
  logic [7:0] rd_data, rd_addr, wr_addr, wr_data;
  logic sda_oe, wr_valid, wr_commit;
  logic [7:0] mem [256];
  logic [15:0] exp_q[$];
  int checks = 0, failures = 0, ncommit = 0;
  bit done = 1'b0;

  wire sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  assign rd_data = mem[rd_addr];

  ee_bus_slave i_ee_bus_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .cs_strap(cs_strap),
    .busy(busy), .rd_data(rd_data), .sda_oe(sda_oe), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference: every strobed byte must match the next expected write
  always @(posedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected write", {wr_addr, wr_data}, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({wr_addr, wr_data} == e, "R4/R5 write strobe", {wr_addr, wr_data}, e);
      end
      mem[wr_addr] = wr_data;
    end
    if (rst_n && wr_commit) ncommit++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q / 2);
      if (glitch && i == 1) begin sda_m = 1'b0; tick(1); sda_m = b[i]; tick(Q / 2 - 1); end
      else tick(Q / 2);
      tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    acked = (sda_line == 1'b0);
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      d = {d[6:0], sda_line};
      tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = ack ? 1'b0 : 1'b1; tick(Q); scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    int c0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    tick(5);
    chk(sda_oe == 1'b0 && wr_valid == 1'b0 && wr_commit == 1'b0, "R1 reset outputs",
        {sda_oe, wr_valid, wr_commit}, 0);
    rst_n = 1'b1; tick(10);

    // R2: wrong strap, wrong code, and ignore-until-Start
    bus_start(); send_byte(8'b1010_011_0, 0, a); chk(!a, "R2 strap mismatch nack", a, 0);
    send_byte(8'h00, 0, a); chk(!a, "R2 ignored after mismatch", a, 0); bus_stop();
    bus_start(); send_byte(8'b1011_101_0, 0, a); chk(!a, "R2 code mismatch nack", a, 0); bus_stop();

    // R4 R6: single byte write
    c0 = ncommit;
    bus_start(); send_byte(8'hAA, 0, a); chk(a, "R2 match ack", a, 1);
    send_byte(8'h10, 0, a); chk(a, "R4 address ack", a, 1);
    exp_q.push_back({8'h10, 8'hA5});
    send_byte(8'hA5, 0, a); chk(a, "R4 data ack", a, 1); bus_stop();
    chk(ncommit == c0 + 1, "R6 one commit", ncommit - c0, 1);

    // R5: page wrap
    bus_start(); send_byte(8'hAA, 0, a); send_byte(8'h1E, 0, a);
    exp_q.push_back({8'h1E, 8'h11}); exp_q.push_back({8'h1F, 8'h22}); exp_q.push_back({8'h10, 8'h33});
    send_byte(8'h11, 0, a); send_byte(8'h22, 0, a); send_byte(8'h33, 0, a);
    chk(a, "R5 third byte ack", a, 1); bus_stop();

    // R10: glitch inside a data bit
    bus_start(); send_byte(8'hAA, 0, a); send_byte(8'h40, 0, a);
    exp_q.push_back({8'h40, 8'hF2});
    send_byte(8'hF2, 1, a); chk(a, "R10 ack after glitch", a, 1); bus_stop();

    // R7: random read, plus R6 no commit for address-only write
    c0 = ncommit;
    bus_start(); send_byte(8'hAA, 0, a); send_byte(8'h1E, 0, a);
    bus_start(); send_byte(8'hAB, 0, a); chk(a, "R7 read control ack", a, 1);
    recv_byte(0, d); chk(d == 8'h11, "R7 random read data", d, 8'h11); bus_stop();
    chk(ncommit == c0, "R6 no commit without data", ncommit - c0, 0);

    // R8: sequential read across 0xFF, R9 release after nack
    mem[8'hFE] = 8'h5A; mem[8'hFF] = 8'hC3; mem[8'h00] = 8'h7E;
    bus_start(); send_byte(8'hAA, 0, a); send_byte(8'hFE, 0, a);
    bus_start(); send_byte(8'hAB, 0, a);
    recv_byte(1, d); chk(d == 8'h5A, "R8 seq byte 0", d, 8'h5A);
    recv_byte(1, d); chk(d == 8'hC3, "R8 seq byte 1", d, 8'hC3);
    recv_byte(0, d); chk(d == 8'h7E, "R8 wrap to 00", d, 8'h7E);
    chk(sda_line == 1'b1, "R9 SDA released", sda_line, 1);
    bus_stop();

    // R9: current-address read repeats the nacked byte
    mem[8'h01] = 8'h99;
    bus_start(); send_byte(8'hAB, 0, a); recv_byte(0, d);
    chk(d == 8'h7E, "R9 pointer held", d, 8'h7E); bus_stop();

    // R3: busy suppresses acknowledge
    busy = 1'b1;
    bus_start(); send_byte(8'hAA, 0, a); chk(!a, "R3 busy nack", a, 0); bus_stop();
    busy = 1'b0;
    bus_start(); send_byte(8'hAA, 0, a); chk(a, "R3 ack after busy", a, 1); bus_stop();

    chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule